// File: doc/BRIEF.md
# Unit-Circle Eigenvalue Generator

This block produces, one request at a time, the complex value exp(−jπα/2) that a fractional-order transform engine multiplies into each spectral coefficient. A controller places a signed fixed-point order on `order_in` and raises `start`. The block adds that value into a running phase register α and then returns the point on the unit circle for the new α. The real part is cos(πα/2) and the imaginary part is −sin(πα/2), both in signed Q2.30. Sending 0 on the first request gives α = 0. Sending the same order on every later request steps α through a, 2a, 3a and so on. Sending twice the order on a final request skips one step of the sequence.

Whole-number phases never reach the rotation engine. When the fraction bits of α are all zero, the block returns the exact value 1, −j, −1 or +j on the next cycle. Any other phase is split into a quadrant and a residual angle. The residual angle is scaled by π/2 and rotated by an internal shift-and-add CORDIC with a fixed number of iterations. The sine and cosine that come out are then swapped and negated to suit the quadrant. α wraps modulo 4 by plain two's-complement overflow, and exp(−jπα/2) has period 4 in α, so the wrap gives the correct value.

Top module: `eig_phase_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `done`, `re_out` and `im_out` are all 0.
- R2: A `start` that is sampled high while the block is idle adds `order_in` into α and drives `done` low after that same clock edge. Values are signed Q2.30, so 1.0 is 0x4000_0000.
- R3: If bits [29:0] of the new α are zero, the result appears with `done` high one clock edge after the edge that accepted `start`. The result is exact. Bits [31:30] of α map as follows: 00 gives (0x4000_0000, 0), 01 gives (0, 0xC000_0000), 10 gives (0xC000_0000, 0), and 11 gives (0, 0x4000_0000).
- R4: For any other α, `done` rises on the 16th clock edge after the edge that accepted `start`. `re_out` and `im_out` then match cos(πα/2) and −sin(πα/2) within 2^19 LSB.
- R5: The result is correct in all four quadrants of α, which are selected by bits [31:30], including phases just below a quadrant boundary and phases a few LSB above zero.
- R6: A `start` sampled while a request is still in progress, including in the very edge at which the result lands, has no effect. α is not changed, no extra result is produced, and the pending result is unchanged.
- R7: While `done` is high and `start` is low, `done`, `re_out` and `im_out` hold their values.
- R8: α wraps modulo 4.0. For example, four steps of 1.0 from α = 0 return the result for α = 0, which is (0x4000_0000, 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears α and the outputs |
| start | input | 1 | Request strobe; sampled only while the block is idle |
| order_in | input | 32 | Signed Q2.30 phase step added into α on an accepted request |
| re_out | output | 32 | Signed Q2.30 real part, cos(πα/2) |
| im_out | output | 32 | Signed Q2.30 imaginary part, −sin(πα/2) |
| done | output | 1 | High from the moment a result is valid until the next accepted request |

## Verification
Two events can share one clock edge: a new `start` and the completion of a request that is still in progress. The bench provokes this case in two ways. It raises `start` so that it is sampled on the exact edge at which the CORDIC result is written, and it holds `start` high into the phase-check cycle. The collision is judged correct when three things hold: no extra result is delivered, the in-flight result still matches the model, and the next real request shows that α was never touched. Back-to-back requests issued on the cycle right after `done` confirm that the idle state accepts work at once.

// File: rtl/eig_pkg.sv
package eig_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned FRAC_W       = 30;
    localparam int unsigned CORDIC_ITERS = 14;

    typedef logic signed [DATA_W-1:0] q_t;

    localparam q_t Q_ONE      = 32'sh4000_0000;
    localparam q_t Q_NEG_ONE  = -32'sh4000_0000;
    localparam q_t HALF_PI_Q  = 32'sh6487_ED51;
    localparam q_t CORDIC_K_Q = 32'sd652032874;

    typedef enum logic [1:0] {
        ST_ACC   = 2'd0,
        ST_CHECK = 2'd1,
        ST_WAIT  = 2'd2
    } eig_state_t;

    typedef struct packed {
        q_t re;
        q_t im;
    } cplx_t;

    typedef struct packed {
        q_t x;
        q_t y;
        q_t z;
    } rot_t;

    // arctan(2^-i) in Q2.30; beyond i = 9 the small-angle value 2^-i is exact enough
    function automatic q_t atan_q(input int i);
        case (i)
            0:       atan_q = 32'sd843314857;
            1:       atan_q = 32'sd497837829;
            2:       atan_q = 32'sd263043837;
            3:       atan_q = 32'sd133525159;
            4:       atan_q = 32'sd67021687;
            5:       atan_q = 32'sd33543516;
            6:       atan_q = 32'sd16775851;
            7:       atan_q = 32'sd8388437;
            8:       atan_q = 32'sd4194283;
            9:       atan_q = 32'sd2097149;
            default: atan_q = q_t'(32'h4000_0000 >> i);
        endcase
    endfunction

    // exact point for a whole-number phase, selected by its two integer bits
    function automatic cplx_t trivial_point(input logic [1:0] quad);
        cplx_t p;
        case (quad)
            2'b00:   begin p.re = Q_ONE;     p.im = '0;        end
            2'b01:   begin p.re = '0;        p.im = Q_NEG_ONE; end
            2'b10:   begin p.re = Q_NEG_ONE; p.im = '0;        end
            default: begin p.re = '0;        p.im = Q_ONE;     end
        endcase
        return p;
    endfunction

    // rebuild (cos, -sin) of the full phase from the residual-angle cos c and sin s
    function automatic cplx_t quad_rotate(input logic [1:0] quad, input q_t c, input q_t s);
        cplx_t p;
        case (quad)
            2'b00:   begin p.re = c;  p.im = -s; end
            2'b01:   begin p.re = -s; p.im = -c; end
            2'b10:   begin p.re = -c; p.im = s;  end
            default: begin p.re = s;  p.im = c;  end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eig_phase_acc.sv
module eig_phase_acc
    import eig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       add_en,
    input  q_t         order_i,
    output logic [1:0] quad_o,
    output logic       trivial_o,
    output q_t         angle_o
);

    q_t alpha_q;

    // modulo-4 wrap comes for free from two's-complement overflow
    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= '0;
        end else if (add_en) begin
            alpha_q <= alpha_q + order_i;
        end
    end

    always_comb begin
        quad_o    = alpha_q[DATA_W-1 -: 2];
        trivial_o = (alpha_q[FRAC_W-1:0] == '0);
        // residual fraction of a quarter turn times pi/2, back to Q2.30
        angle_o   = q_t'((64'(alpha_q[FRAC_W-1:0]) * 64'(HALF_PI_Q)) >> FRAC_W);
    end

endmodule

// File: rtl/eig_cordic.sv
module eig_cordic
    import eig_pkg::*;
#(
    parameter int unsigned ITERS = CORDIC_ITERS
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  q_t   angle_i,
    output q_t   cos_o,
    output q_t   sin_o,
    output logic last_o
);

    localparam int unsigned CW = $clog2(ITERS + 1);
    localparam logic [CW-1:0] STEP_END = CW'(ITERS);

    q_t atan_tab [ITERS];

    for (genvar g = 0; g < ITERS; g++) begin : g_atan
        assign atan_tab[g] = atan_q(g);
    end

    rot_t          st_q;
    rot_t          st_nxt;
    logic [CW-1:0] step_q;
    logic [CW-1:0] tab_idx;
    logic          rot_pos;
    q_t            x_sh;
    q_t            y_sh;

    always_comb begin
        tab_idx = (step_q < STEP_END) ? step_q : '0;
        rot_pos = ~st_q.z[DATA_W-1];
        x_sh    = st_q.x >>> step_q;
        y_sh    = st_q.y >>> step_q;
        if (rot_pos) begin
            st_nxt.x = st_q.x - y_sh;
            st_nxt.y = st_q.y + x_sh;
            st_nxt.z = st_q.z - atan_tab[tab_idx];
        end else begin
            st_nxt.x = st_q.x + y_sh;
            st_nxt.y = st_q.y - x_sh;
            st_nxt.z = st_q.z + atan_tab[tab_idx];
        end
    end

    // gain is pre-compensated by starting x at 1/K
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            step_q <= STEP_END;
        end else if (load) begin
            st_q.x <= CORDIC_K_Q;
            st_q.y <= '0;
            st_q.z <= angle_i;
            step_q <= '0;
        end else if (step_q != STEP_END) begin
            st_q   <= st_nxt;
            step_q <= step_q + 1'b1;
        end
    end

    assign cos_o  = st_q.x;
    assign sin_o  = st_q.y;
    assign last_o = (step_q == STEP_END);

endmodule

// File: rtl/eig_ctrl.sv
module eig_ctrl
    import eig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic trivial,
    input  logic cordic_last,
    output logic add_en,
    output logic clr_done,
    output logic cordic_load,
    output logic take_triv,
    output logic take_rot,
    output logic busy
);

    eig_state_t state_q;
    eig_state_t state_nxt;

    always_comb begin
        state_nxt   = state_q;
        add_en      = 1'b0;
        clr_done    = 1'b0;
        cordic_load = 1'b0;
        take_triv   = 1'b0;
        take_rot    = 1'b0;
        case (state_q)
            ST_ACC: begin
                if (start) begin
                    add_en    = 1'b1;
                    clr_done  = 1'b1;
                    state_nxt = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (trivial) begin
                    take_triv = 1'b1;
                    state_nxt = ST_ACC;
                end else begin
                    cordic_load = 1'b1;
                    state_nxt   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cordic_last) begin
                    take_rot  = 1'b1;
                    state_nxt = ST_ACC;
                end
            end
            default: state_nxt = ST_ACC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACC;
        end else begin
            state_q <= state_nxt;
        end
    end

    assign busy = (state_q != ST_ACC);

endmodule

// File: rtl/eig_out_reg.sv
module eig_out_reg
    import eig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_done,
    input  logic       take_triv,
    input  logic       take_rot,
    input  logic [1:0] quad,
    input  q_t         cos_i,
    input  q_t         sin_i,
    output q_t         re_o,
    output q_t         im_o,
    output logic       done_o
);

    cplx_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_o <= 1'b0;
        end else if (take_triv) begin
            res_q  <= trivial_point(quad);
            done_o <= 1'b1;
        end else if (take_rot) begin
            res_q  <= quad_rotate(quad, cos_i, sin_i);
            done_o <= 1'b1;
        end else if (clr_done) begin
            done_o <= 1'b0;
        end
    end

    assign re_o = res_q.re;
    assign im_o = res_q.im;

endmodule

// File: rtl/eig_phase_gen.sv
module eig_phase_gen
    import eig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] order_in,
    output logic [DATA_W-1:0] re_out,
    output logic [DATA_W-1:0] im_out,
    output logic              done
);

    logic       add_en;
    logic       clr_done;
    logic       cordic_load;
    logic       take_triv;
    logic       take_rot;
    logic       busy;
    logic       trivial;
    logic       cordic_last;
    logic [1:0] quad;
    q_t         angle;
    q_t         cos_v;
    q_t         sin_v;
    q_t         re_v;
    q_t         im_v;

    eig_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .trivial     (trivial),
        .cordic_last (cordic_last),
        .add_en      (add_en),
        .clr_done    (clr_done),
        .cordic_load (cordic_load),
        .take_triv   (take_triv),
        .take_rot    (take_rot),
        .busy        (busy)
    );

    eig_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .add_en    (add_en),
        .order_i   (q_t'(order_in)),
        .quad_o    (quad),
        .trivial_o (trivial),
        .angle_o   (angle)
    );

    eig_cordic #(.ITERS(CORDIC_ITERS)) u_cordic (
        .clk     (clk),
        .rst     (rst),
        .load    (cordic_load),
        .angle_i (angle),
        .cos_o   (cos_v),
        .sin_o   (sin_v),
        .last_o  (cordic_last)
    );

    eig_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .clr_done  (clr_done),
        .take_triv (take_triv),
        .take_rot  (take_rot),
        .quad      (quad),
        .cos_i     (cos_v),
        .sin_i     (sin_v),
        .re_o      (re_v),
        .im_o      (im_v),
        .done_o    (done)
    );

    assign re_out = re_v;
    assign im_out = im_v;

endmodule

// File: rtl/eig_phase_gen_chk.sv
module eig_phase_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        done,
    input logic [31:0] re_out,
    input logic [31:0] im_out,
    input logic        busy
);

    logic [4:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_done_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

    assert_finish_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_latency_window_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < 5'd16));

    assert_unit_range_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($signed(re_out) <= 32'sh4000_0000 && $signed(re_out) >= -32'sh4000_0000 &&
                         $signed(im_out) <= 32'sh4000_0000 && $signed(im_out) >= -32'sh4000_0000));

    assert_idle_when_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_result_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(re_out) && $stable(im_out)));

endmodule

bind eig_phase_gen eig_phase_gen_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .re_out (re_out),
    .im_out (im_out),
    .busy   (busy)
);

// File: tb/eig_phase_gen_tb_top.sv
`timescale 1ns/1ps
module eig_phase_gen_tb_top;

    localparam real QSCALE = 1073741824.0;
    localparam real PI_R   = 3.14159265358979;
    localparam int  TOL    = 1 << 19;
    localparam logic [31:0] ONE_Q = 32'h4000_0000;

    typedef struct {
        logic signed [31:0] re;
        logic signed [31:0] im;
        int                 tol;
        int                 issue;
        int                 lat;
        bit                 triv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] order_in = '0;
    logic [31:0] re_out;
    logic [31:0] im_out;
    logic        done;

    int   cyc = 0;
    int   vectors = 0;
    int   fails = 0;
    exp_t exp_q [$];
    logic [31:0] al_m = '0;
    logic [31:0] last_re = '0;
    logic [31:0] last_im = '0;
    logic        done_seen = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    eig_phase_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .order_in (order_in),
        .re_out   (re_out),
        .im_out   (im_out),
        .done     (done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic logic [31:0] to_q(input real v);
        return 32'($rtoi(v * QSCALE));
    endfunction

    // independent model: exact points for whole phases, real trig otherwise
    task automatic model(input logic [31:0] al, output exp_t e);
        real ang;
        e.triv = (al[29:0] == 30'd0);
        if (e.triv) begin
            case (al[31:30])
                2'b00:   begin e.re = ONE_Q;  e.im = 0;      end
                2'b01:   begin e.re = 0;      e.im = -ONE_Q; end
                2'b10:   begin e.re = -ONE_Q; e.im = 0;      end
                default: begin e.re = 0;      e.im = ONE_Q;  end
            endcase
            e.tol = 0;
            e.lat = 1;
        end else begin
            ang  = ($itor($signed(al)) / QSCALE) * PI_R / 2.0;
            e.re = $rtoi($cos(ang) * QSCALE);
            e.im = $rtoi(-$sin(ang) * QSCALE);
            e.tol = TOL;
            e.lat = 16;
        end
    endtask

    // monitor: pops one expectation per rising done
    always @(negedge clk) begin
        longint dr;
        longint di;
        exp_t   e;
        if (!rst && done && !done_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected result", 1, 0);
            end else begin
                e  = exp_q.pop_front();
                dr = longint'($signed(re_out)) - longint'(e.re);
                di = longint'($signed(im_out)) - longint'(e.im);
                if (dr < 0) dr = -dr;
                if (di < 0) di = -di;
                if (e.triv) begin
                    check(dr == 0, "R3 real", longint'($signed(re_out)), longint'(e.re));
                    check(di == 0, "R3 imag", longint'($signed(im_out)), longint'(e.im));
                    check(cyc - e.issue == e.lat, "R3 latency", cyc - e.issue, e.lat);
                end else begin
                    check(dr <= e.tol, "R4 R5 real", longint'($signed(re_out)), longint'(e.re));
                    check(di <= e.tol, "R4 R5 imag", longint'($signed(im_out)), longint'(e.im));
                    check(cyc - e.issue == e.lat, "R4 latency", cyc - e.issue, e.lat);
                end
            end
            last_re = re_out;
            last_im = im_out;
        end
        done_seen = done;
    end

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // mode 0: plain, 1: start held into the check cycle, 2: start hits the completion edge
    task automatic request(input logic [31:0] ord, input int mode);
        exp_t e;
        wait_idle();
        al_m = al_m + ord;
        model(al_m, e);
        e.issue = cyc + 1;
        exp_q.push_back(e);
        start    = 1'b1;
        order_in = ord;
        @(negedge clk);
        check(done == 1'b0, "R2 done cleared", done, 0);
        if (mode == 1) begin
            order_in = to_q(0.777);
            @(negedge clk);
        end
        start    = 1'b0;
        order_in = '0;
        if (mode == 2) begin
            while (cyc != e.issue + 15) @(negedge clk);
            start    = 1'b1;
            order_in = to_q(-0.55);
            @(negedge clk);
            start    = 1'b0;
            order_in = '0;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] a_q;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(done == 1'b0, "R1 done", done, 0);
        check(re_out == 32'd0, "R1 re", re_out, 0);
        check(im_out == 32'd0, "R1 im", im_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && re_out == 0 && im_out == 0, "R1 after release", done, 0);

        request(32'd0, 0);

        // quadrant sweep with a positive order, crossing a boundary from just below, then wrapping (R5, R8)
        a_q = to_q(0.3);
        for (int k = 0; k < 14; k++) request(a_q, 0);
        // doubled order skips one step
        request(a_q + a_q, 0);

        // R7 hold while idle
        wait_idle();
        repeat (6) @(negedge clk);
        check(done == 1'b1, "R7 done held", done, 1);
        check(re_out == last_re && im_out == last_im, "R7 value held", re_out, last_re);

        // negative order
        a_q = to_q(-0.7);
        for (int k = 0; k < 8; k++) request(a_q, 0);

        // return to zero, then whole steps: all trivial points and the modulo-4 wrap
        request(32'(-al_m), 0);
        request(ONE_Q, 0);
        request(ONE_Q, 1);
        request(ONE_Q, 0);
        request(ONE_Q, 0);
        wait_idle();
        check(re_out == ONE_Q && im_out == 0, "R8 wrap to zero phase", re_out, ONE_Q);
        request(ONE_Q, 1);
        wait_idle();
        // the start held into the check cycle must not have moved the phase
        request(ONE_Q, 0);

        // start sampled on the completion edge is dropped (R6)
        request(to_q(0.45), 2);
        wait_idle();
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && done == 1'b1, "R6 no extra request", exp_q.size(), 0);
        request(to_q(0.2), 2);
        request(to_q(0.1), 0);

        // tiny residual angle and large orders (R5)
        request(32'(-al_m), 0);
        request(32'd3, 0);
        request(to_q(-1.999), 0);
        request(to_q(1.25), 0);
        request(32'h8000_0000, 0);

        wait_idle();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule